// File: doc/BRIEF.md
# Logical-Instruction Byte Stream Parser

This block sits between an instruction byte source and an execution stage. It accepts one byte per valid/ready handshake and rebuilds a two-operand bitwise-logic instruction. The first byte is the opcode. The second is the mode byte. Depending on the mode and the operand size, zero to four more bytes follow, carrying an address, a displacement or an immediate. Once the last byte has arrived, the block presents one decoded record. The record gives the operand size, the kind of destination and source, the register indices, the 16-bit address or displacement, the immediate and the instruction length.

The record stays in place until the consumer accepts it through a separate valid/ready pair. While it is pending, the input is back-pressured. A malformed opcode or mode byte produces a one-cycle error pulse, and the parser then waits for a new opcode. The block only parses: it fetches nothing, computes no addresses and executes nothing.

Top module: `lgc_insn_parser`

## Requirements
- R1: An input byte whose upper seven bits are 1000010 is taken as the opcode. Its bit 0 is the wide flag (`rec_wide`): 0 selects byte operands and 1 selects 16-bit operands. Any other byte in the opcode position is consumed and raises `err`.
- R2: A mode byte with bits 7:6 = 00 gives a register-to-register form with no trailing bytes. Bits 5:3 are the source register and bits 2:0 are the destination register. `rec_dst_kind` = 0 and `rec_src_kind` = 0.
- R3: When mode bit 6 is 1, bits 5:4 select the memory form: 00 is direct, 01 is indirect and 10 is indirect with displacement. Mode bit 3 = 1 makes the source an immediate. Mode bit 7 = 0 puts the register in bits 2:0 at the destination, and mode bit 7 = 1 makes the memory operand the destination. Destination kind codes are 0 register, 1 direct, 2 indirect and 3 indirect+displacement. Source kind codes are 0 register, 1 immediate, 2 direct, 3 indirect and 4 indirect+displacement.
- R4: The direct and displacement forms take two trailing bytes, low byte first, into `rec_addr`. The plain indirect form takes none, and `rec_addr` reads 0.
- R5: An immediate takes its low byte and then its high byte into `rec_imm`. In byte mode only the low byte is present and `rec_imm[15:8]` reads 0.
- R6: In the immediate-to-memory form, the address or displacement bytes come before the data bytes, and mode bits 2:0 must be 000.
- R7: In wide mode, a register code above 4 in any register field raises `err`. In byte mode all eight codes are accepted.
- R8: The following are all errors: mode bits 5:4 = 11 in a memory form, mode bits 7:6 = 10, an immediate-to-register form with bits 5:4 other than 00, and an immediate-to-memory form with bits 2:0 other than 000. An error pulses `err` for exactly one cycle, produces no record and returns the parser to waiting for an opcode.
- R9: `rec_len` equals 2, plus 2 when an address or displacement is present, plus 1 or 2 for a byte or wide immediate. Its range is 2 to 6.
- R10: While `rec_valid` is high, `in_ready` is low and every record field stays unchanged until `rec_ready` is seen. An input byte offered during that time is not consumed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input byte offered |
| in_data | input | 8 | Input byte |
| in_ready | output | 1 | Parser can take a byte |
| rec_valid | output | 1 | Decoded record available |
| rec_ready | input | 1 | Consumer takes the record |
| rec_wide | output | 1 | 1 = 16-bit operands |
| rec_dst_kind | output | 2 | Destination kind code |
| rec_src_kind | output | 3 | Source kind code |
| rec_dst_reg | output | 3 | Destination register index |
| rec_src_reg | output | 3 | Source register index |
| rec_addr | output | 16 | Address or displacement |
| rec_imm | output | 16 | Immediate value |
| rec_len | output | 3 | Instruction length in bytes |
| err | output | 1 | One-cycle malformed-instruction pulse |

## Verification
Complete instructions of every length from 2 to 6 bytes are fed in, covering both sizes.

- **Register-to-register, including code 7 in byte mode:** confirms the field order and the per-size register limit.
- **Immediate-to-register, byte and wide:** separates the dropped high data byte from a present one.
- **Direct, indirect and displacement memory forms:** shows that the trailing-byte count follows mode bits 5:4.
- **Immediate-to-memory:** proves that the address bytes are placed ahead of the data bytes.
- **Malformed bytes, each followed by a good instruction:** checks that the parser resynchronises.
- **Byte offered while a record is held:** checks back-pressure and record stability.

// File: rtl/lip_pkg.sv
package lip_pkg;
  localparam int BYTE_W     = 8;
  localparam int WORD_BYTES = 2;
  localparam int WORD_W     = BYTE_W * WORD_BYTES;
  localparam int REG_W      = 3;
  localparam int CNT_W      = $clog2(WORD_BYTES) + 1;

  typedef enum logic [1:0] {DK_REG = 2'd0, DK_DIR = 2'd1, DK_IND = 2'd2, DK_DSP = 2'd3} dst_kind_t;
  typedef enum logic [2:0] {SK_REG = 3'd0, SK_IMM = 3'd1, SK_DIR = 3'd2, SK_IND = 3'd3, SK_DSP = 3'd4} src_kind_t;

  typedef struct packed {
    dst_kind_t        dk;
    src_kind_t        sk;
    logic [REG_W-1:0] dreg;
    logic [REG_W-1:0] sreg;
    logic [CNT_W-1:0] addr_n;
    logic [CNT_W-1:0] imm_n;
  } form_t;
endpackage

// File: rtl/lip_mode_decode.sv
module lip_mode_decode
  import lip_pkg::*;
#(
  parameter int WIDE_REG_MAX = 4
) (
  input  logic [BYTE_W-1:0] mode,
  input  logic              wide,
  output form_t             form,
  output logic              bad
);
  logic      amode_bad;
  logic      imm_flag;
  logic      reg_lo_bad;
  logic      reg_hi_bad;
  dst_kind_t mem_dk;
  src_kind_t mem_sk;
  logic [CNT_W-1:0] mem_n;
  logic [CNT_W-1:0] imm_len;

  always_comb begin
    imm_flag   = mode[3];
    reg_lo_bad = wide && (int'(mode[2:0]) > WIDE_REG_MAX);
    reg_hi_bad = wide && (int'(mode[5:3]) > WIDE_REG_MAX);
    imm_len    = wide ? CNT_W'(WORD_BYTES) : CNT_W'(1);
    amode_bad  = 1'b0;
    mem_dk     = DK_DIR;
    mem_sk     = SK_DIR;
    mem_n      = CNT_W'(WORD_BYTES);
    case (mode[5:4])
      2'b00: begin mem_dk = DK_DIR; mem_sk = SK_DIR; mem_n = CNT_W'(WORD_BYTES); end
      2'b01: begin mem_dk = DK_IND; mem_sk = SK_IND; mem_n = '0; end
      2'b10: begin mem_dk = DK_DSP; mem_sk = SK_DSP; mem_n = CNT_W'(WORD_BYTES); end
      default: amode_bad = 1'b1;
    endcase
  end

  always_comb begin
    form = '0;
    bad  = 1'b0;
    case (mode[7:6])
      2'b00: begin
        form.dk   = DK_REG;
        form.sk   = SK_REG;
        form.dreg = mode[2:0];
        form.sreg = mode[5:3];
        bad       = reg_lo_bad || reg_hi_bad;
      end
      2'b01: begin
        form.dk   = DK_REG;
        form.dreg = mode[2:0];
        if (imm_flag) begin
          form.sk    = SK_IMM;
          form.imm_n = imm_len;
          bad        = reg_lo_bad || (mode[5:4] != 2'b00);
        end else begin
          form.sk     = mem_sk;
          form.addr_n = mem_n;
          bad         = reg_lo_bad || amode_bad;
        end
      end
      2'b11: begin
        form.dk     = mem_dk;
        form.addr_n = mem_n;
        if (imm_flag) begin
          form.sk    = SK_IMM;
          form.imm_n = imm_len;
          bad        = amode_bad || (mode[2:0] != 3'b000);
        end else begin
          form.sk   = SK_REG;
          form.sreg = mode[2:0];
          bad       = amode_bad || reg_lo_bad;
        end
      end
      default: bad = 1'b1;
    endcase
  end
endmodule

// File: rtl/lip_tail_store.sv
module lip_tail_store
  import lip_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              take,
  input  logic [BYTE_W-1:0] byte_in,
  input  logic [CNT_W-1:0]  addr_n,
  output logic [2:0]        idx,
  output logic [WORD_W-1:0] addr,
  output logic [WORD_W-1:0] imm
);
  logic [2:0]        idx_q, idx_d;
  logic [WORD_W-1:0] addr_q, addr_d, imm_q, imm_d;
  logic              upd;

  always_comb begin
    upd    = clr || take;
    idx_d  = idx_q;
    addr_d = addr_q;
    imm_d  = imm_q;
    if (clr) begin
      idx_d  = '0;
      addr_d = '0;
      imm_d  = '0;
    end else if (take) begin
      for (int b = 0; b < WORD_BYTES; b++) begin
        if ((idx_q == 3'(b)) && (3'(b) < 3'(addr_n)))
          addr_d[b*BYTE_W +: BYTE_W] = byte_in;
        if (idx_q == (3'(addr_n) + 3'(b)))
          imm_d[b*BYTE_W +: BYTE_W] = byte_in;
      end
      idx_d = idx_q + 3'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      addr_q <= '0;
      imm_q  <= '0;
    end else if (upd) begin
      idx_q  <= idx_d;
      addr_q <= addr_d;
      imm_q  <= imm_d;
    end
  end

  assign idx  = idx_q;
  assign addr = addr_q;
  assign imm  = imm_q;
endmodule

// File: rtl/lgc_insn_parser.sv
module lgc_insn_parser
  import lip_pkg::*;
#(
  parameter logic [6:0] OPC_MATCH    = 7'b1000010,
  parameter int         WIDE_REG_MAX = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [7:0]  in_data,
  output logic        in_ready,
  output logic        rec_valid,
  input  logic        rec_ready,
  output logic        rec_wide,
  output logic [1:0]  rec_dst_kind,
  output logic [2:0]  rec_src_kind,
  output logic [2:0]  rec_dst_reg,
  output logic [2:0]  rec_src_reg,
  output logic [15:0] rec_addr,
  output logic [15:0] rec_imm,
  output logic [2:0]  rec_len,
  output logic        err
);
  typedef enum logic [1:0] {S_OP, S_MODE, S_TAIL, S_OUT} st_t;

  st_t   state_q, state_d;
  logic  wide_q, wide_d, wide_en;
  form_t form_q, form_d, dec;
  logic  form_en;
  logic  err_q, err_d;
  logic  dec_bad, fire, clr, take;
  logic [2:0] idx, tot_q, tot_dec;

  lip_mode_decode #(.WIDE_REG_MAX(WIDE_REG_MAX)) u_dec (
    .mode(in_data), .wide(wide_q), .form(dec), .bad(dec_bad)
  );

  lip_tail_store u_tail (
    .clk(clk), .rst_n(rst_n), .clr(clr), .take(take), .byte_in(in_data),
    .addr_n(form_q.addr_n), .idx(idx), .addr(rec_addr), .imm(rec_imm)
  );

  always_comb begin
    in_ready = (state_q != S_OUT);
    fire     = in_valid && in_ready;
    tot_q    = 3'(form_q.addr_n) + 3'(form_q.imm_n);
    tot_dec  = 3'(dec.addr_n) + 3'(dec.imm_n);
  end

  always_comb begin
    state_d = state_q;
    wide_d  = wide_q;
    wide_en = 1'b0;
    form_d  = form_q;
    form_en = 1'b0;
    err_d   = 1'b0;
    clr     = 1'b0;
    take    = 1'b0;
    case (state_q)
      S_OP: if (fire) begin
        if (in_data[7:1] == OPC_MATCH) begin
          wide_d  = in_data[0];
          wide_en = 1'b1;
          state_d = S_MODE;
        end else begin
          err_d = 1'b1;
        end
      end
      S_MODE: if (fire) begin
        if (dec_bad) begin
          err_d   = 1'b1;
          state_d = S_OP;
        end else begin
          form_d  = dec;
          form_en = 1'b1;
          clr     = 1'b1;
          state_d = (tot_dec == 3'd0) ? S_OUT : S_TAIL;
        end
      end
      S_TAIL: if (fire) begin
        take = 1'b1;
        if (idx + 3'd1 == tot_q) state_d = S_OUT;
      end
      default: if (rec_ready) state_d = S_OP;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_OP;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      err_q   <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       wide_q <= 1'b0;
    else if (wide_en) wide_q <= wide_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       form_q <= '0;
    else if (form_en) form_q <= form_d;
  end

  assign rec_valid    = (state_q == S_OUT);
  assign rec_wide     = wide_q;
  assign rec_dst_kind = form_q.dk;
  assign rec_src_kind = form_q.sk;
  assign rec_dst_reg  = form_q.dreg;
  assign rec_src_reg  = form_q.sreg;
  assign rec_len      = 3'd2 + tot_q;
  assign err          = err_q;
endmodule

// File: rtl/lip_chk.sv
module lip_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_ready,
  input logic        rec_valid,
  input logic        rec_ready,
  input logic        rec_wide,
  input logic [1:0]  rec_dst_kind,
  input logic [2:0]  rec_src_kind,
  input logic [2:0]  rec_dst_reg,
  input logic [2:0]  rec_src_reg,
  input logic [15:0] rec_addr,
  input logic [15:0] rec_imm,
  input logic [2:0]  rec_len,
  input logic        err
);
  // R10
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid && !rec_ready |=> rec_valid && $stable(rec_addr) && $stable(rec_imm)
      && $stable(rec_len) && $stable(rec_dst_kind) && $stable(rec_src_kind));

  // R10
  backpressure_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid |-> !in_ready);

  // R9
  len_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid |-> (rec_len >= 3'd2) && (rec_len <= 3'd6));

  // R9
  len_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid |-> rec_len == 3'd2
      + ((rec_dst_kind == 2'd1 || rec_dst_kind == 2'd3 || rec_src_kind == 3'd2 || rec_src_kind == 3'd4) ? 3'd2 : 3'd0)
      + ((rec_src_kind == 3'd1) ? (rec_wide ? 3'd2 : 3'd1) : 3'd0));

  // R5
  byte_imm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid && !rec_wide |-> rec_imm[15:8] == 8'h00);

  // R7
  wide_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid && rec_wide |-> (rec_dst_reg <= 3'd4) && (rec_src_reg <= 3'd4));

  // R8
  err_norec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !rec_valid);

  // R8
  err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> !err);
endmodule

bind lgc_insn_parser lip_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .rec_valid(rec_valid),
  .rec_ready(rec_ready), .rec_wide(rec_wide), .rec_dst_kind(rec_dst_kind),
  .rec_src_kind(rec_src_kind), .rec_dst_reg(rec_dst_reg), .rec_src_reg(rec_src_reg),
  .rec_addr(rec_addr), .rec_imm(rec_imm), .rec_len(rec_len), .err(err)
);

// File: tb/lgc_insn_parser_test.sv
`timescale 1ns/1ps
module lgc_insn_parser_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = 8'h00;
  logic        rec_ready = 1'b0;
  logic        in_ready, rec_valid, rec_wide, err;
  logic [1:0]  rec_dst_kind;
  logic [2:0]  rec_src_kind, rec_dst_reg, rec_src_reg, rec_len;
  logic [15:0] rec_addr, rec_imm;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  lgc_insn_parser uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .rec_valid(rec_valid), .rec_ready(rec_ready),
    .rec_wide(rec_wide), .rec_dst_kind(rec_dst_kind), .rec_src_kind(rec_src_kind),
    .rec_dst_reg(rec_dst_reg), .rec_src_reg(rec_src_reg), .rec_addr(rec_addr),
    .rec_imm(rec_imm), .rec_len(rec_len), .err(err)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(logic [7:0] b);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = b;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic expect_rec(string req, logic w, logic [1:0] dk, logic [2:0] sk,
                            logic [2:0] dr, logic [2:0] sr, logic [15:0] ad,
                            logic [15:0] im, logic [2:0] ln);
    check({req, " valid"}, rec_valid, 1'b1);
    check({req, " wide"}, rec_wide, w);
    check({req, " dst_kind"}, rec_dst_kind, dk);
    check({req, " src_kind"}, rec_src_kind, sk);
    check({req, " dst_reg"}, rec_dst_reg, dr);
    check({req, " src_reg"}, rec_src_reg, sr);
    check({req, " addr"}, rec_addr, ad);
    check({req, " imm"}, rec_imm, im);
    check({req, " len R9"}, rec_len, ln);
    rec_ready = 1'b1;
    @(negedge clk);
    rec_ready = 1'b0;
    check({req, " released"}, rec_valid, 1'b0);
  endtask

  task automatic t_reset();
    check("R10 reset rec_valid", rec_valid, 1'b0);
    check("R10 reset in_ready", in_ready, 1'b1);
    check("R8 reset err", err, 1'b0);
  endtask

  task automatic t_regreg();
    send(8'h84); send(8'h19);               // R2: src BL(3), dst CL(1)
    expect_rec("R2 byte", 1'b0, 2'd0, 3'd0, 3'd1, 3'd3, 16'h0, 16'h0, 3'd2);
    send(8'h84); send(8'h3F);               // R7: code 7 legal in byte mode
    check("R7 no err byte code 7", err, 1'b0);
    expect_rec("R7 byte code 7", 1'b0, 2'd0, 3'd0, 3'd7, 3'd7, 16'h0, 16'h0, 3'd2);
    send(8'h85); send(8'h20);               // R1 wide, src 4 dst 0
    expect_rec("R1 wide", 1'b1, 2'd0, 3'd0, 3'd0, 3'd4, 16'h0, 16'h0, 3'd2);
  endtask

  task automatic t_imm_reg();
    send(8'h85); send(8'h4A); send(8'h34); send(8'h12);
    expect_rec("R5 wide imm", 1'b1, 2'd0, 3'd1, 3'd2, 3'd0, 16'h0, 16'h1234, 3'd4);
    send(8'h84); send(8'h4A); send(8'h7F);
    expect_rec("R5 byte imm", 1'b0, 2'd0, 3'd1, 3'd2, 3'd0, 16'h0, 16'h007F, 3'd3);
  endtask

  task automatic t_mem_forms();
    send(8'h85); send(8'h40); send(8'hCD); send(8'hAB);
    expect_rec("R4 direct src", 1'b1, 2'd0, 3'd2, 3'd0, 3'd0, 16'hABCD, 16'h0, 3'd4);
    send(8'h85); send(8'hD4);
    expect_rec("R3 indirect dst", 1'b1, 2'd2, 3'd0, 3'd0, 3'd4, 16'h0, 16'h0, 3'd2);
    send(8'h84); send(8'h63); send(8'h22); send(8'h11);
    expect_rec("R4 disp src", 1'b0, 2'd0, 3'd4, 3'd3, 3'd0, 16'h1122, 16'h0, 3'd4);
  endtask

  task automatic t_imm_mem();
    send(8'h85); send(8'hE8); send(8'h10); send(8'h20); send(8'h78); send(8'h56);
    expect_rec("R6 disp wide imm", 1'b1, 2'd3, 3'd1, 3'd0, 3'd0, 16'h2010, 16'h5678, 3'd6);
    send(8'h84); send(8'hC8); send(8'h00); send(8'h40); send(8'h99);
    expect_rec("R6 direct byte imm", 1'b0, 2'd1, 3'd1, 3'd0, 3'd0, 16'h4000, 16'h0099, 3'd5);
    send(8'h84); send(8'hD8); send(8'h5A);
    expect_rec("R6 indirect byte imm", 1'b0, 2'd2, 3'd1, 3'd0, 3'd0, 16'h0, 16'h005A, 3'd3);
  endtask

  task automatic t_errors();
    send(8'h90);
    check("R1 bad opcode err", err, 1'b1);
    @(negedge clk);
    check("R8 err one cycle", err, 1'b0);
    send(8'h85); send(8'h05);
    check("R7 wide code 5 err", err, 1'b1);
    check("R8 no record after err", rec_valid, 1'b0);
    send(8'h84); send(8'h70);
    check("R8 mode 11 err", err, 1'b1);
    send(8'h84); send(8'h80);
    check("R8 mode bits 10 err", err, 1'b1);
    send(8'h84); send(8'hC9);
    check("R6 imm-mem low bits err", err, 1'b1);
    send(8'h84); send(8'h12);
    check("R8 resync no err", err, 1'b0);
    expect_rec("R8 resync", 1'b0, 2'd0, 3'd0, 3'd2, 3'd2, 16'h0, 16'h0, 3'd2);
  endtask

  task automatic t_backpressure();
    send(8'h85); send(8'h40); send(8'h34); send(8'h12);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = 8'h84;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R10 held in_ready low", in_ready, 1'b0);
      check("R10 held addr", rec_addr, 16'h1234);
    end
    rec_ready = 1'b1;
    @(negedge clk);
    rec_ready = 1'b0;
    @(negedge clk);
    in_valid = 1'b0;
    send(8'h19);
    expect_rec("R10 byte kept", 1'b0, 2'd0, 3'd0, 3'd1, 3'd3, 16'h0, 16'h0, 3'd2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regreg();
    t_imm_reg();
    t_mem_forms();
    t_imm_mem();
    t_errors();
    t_backpressure();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(5ns * 20000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule